// File: doc/BRIEF.md
# Serial Port Loopback and Modem-Status Mirror

This block sits beside the control register of a serial port and implements its internal loopback mode. A control register write that carries the loopback-enable bit makes the four software-driven modem outputs appear at once on the four modem-status flags. The same write recomputes the modem-status interrupt bits so that each one equals its flag level. While loopback is on, every transmit data write and every rising edge of the send-break control comes back as an entry pushed toward the receive buffer. Bytes from the external receive input are dropped in that mode and passed through when it is off.

The block receives the control write strobe with its data, transmit write strobes with data, writes to the send-break control, external received bytes and a ready level from the receive buffer. Its outputs are the flag and interrupt bits, a single-cycle push request with a receive entry, and a level that tells the receive path external bytes are being blocked. Bit-level serial timing and hardware flow control are handled elsewhere.

Top module: `lbk_modem_mirror`

## Requirements
- R1: After reset the flags, the interrupt bits, the push request and the block level are all zero, loopback is off and the remembered send-break level is 0.
- R2: A control write whose bit 7 (loopback enable) is 1 sets the flags to: bit 0 (clear-to-send) from control bit 9, bit 1 (data-set-ready) from control bit 8, bit 2 (carrier-detect) from control bit 10, bit 3 (ring-indicator) from control bit 11. This also applies to a write that only sets bit 7.
- R3: After such a write the four interrupt bits (same order as the flags) are cleared and each is then set when its new flag is 1, so a bit set earlier drops when its flag drops.
- R4: A control write with bit 7 clear turns loopback off and changes neither the flags nor the interrupt bits.
- R5: In loopback, a transmit write pushes one entry whose low 8 bits are the written byte and whose upper 4 bits are 0, with the push request high on the cycle after the write.
- R6: In loopback, a send-break change from 0 to 1 pushes one entry equal to 0x400 (bit 10 set, all else 0); writing 1 while already 1, writing 0, or a rising edge with loopback off pushes nothing.
- R7: When a loopback transmit write and a send-break rising edge occur in the same cycle, the transmit entry is pushed first and the break entry on the next cycle.
- R8: With loopback on, external received bytes are discarded and the block level is 1; with loopback off, each external byte is pushed as an entry with upper 4 bits 0 and the block level is 0.
- R9: A push whose source cycle sees the receive buffer not ready is dropped and not retried, including a pending break entry.
- R10: The push request is a one-cycle pulse for each entry: it falls on the cycle after an entry when no new source occurs.
- R11: With loopback off, a transmit write pushes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_wdata | input | 16 | Control register write value |
| tx_we | input | 1 | Transmit data write strobe |
| tx_wdata | input | 8 | Transmit data byte |
| brk_we | input | 1 | Send-break control write strobe |
| brk_val | input | 1 | New send-break level |
| ext_rx_valid | input | 1 | External byte arrives this cycle |
| ext_rx_data | input | 8 | External received byte |
| rxq_ready | input | 1 | Receive buffer can take an entry this cycle |
| ms_flags | output | 4 | Modem-status flags {ri, dcd, dsr, cts} |
| ms_irq | output | 4 | Modem-status interrupt bits, same order |
| push_valid | output | 1 | One-cycle request to store push_data |
| push_data | output | 12 | Receive entry: byte in bits 7:0, break in bit 10 |
| ext_rx_block | output | 1 | High while external bytes are discarded |

## Verification
Every result of this block is registered once, so flags, interrupt bits, block level and a push all become visible exactly one cycle after the stimulus cycle; the only two-cycle result is the break entry deferred behind a transmit entry. The bench drives each stimulus for one cycle after a falling edge, waits for the next rising edge and compares at the following falling edge, then removes the stimulus. A step with no push expected therefore also confirms that the earlier pulse lasted one cycle, and the deferred break is checked on the idle step that follows.

// File: rtl/lbk_pkg.sv
// Package: shared layout of the modem-status flag and interrupt vectors.
// Assumes every consumer indexes the 4-bit vectors with these constants.
package lbk_pkg;
    localparam int MS_N   = 4;
    localparam int MS_CTS = 0;
    localparam int MS_DSR = 1;
    localparam int MS_DCD = 2;
    localparam int MS_RI  = 3;
endpackage

// File: rtl/lbk_ctrl_mirror.sv
// Control mirror: holds the loopback mode and, on a control write with
// loopback enabled, copies the modem outputs into the status flags and
// recomputes the interrupt bits from those flags.
// Assumes the control write is a single-cycle strobe; reset is synchronous.
module lbk_ctrl_mirror
    import lbk_pkg::*;
#(
    parameter int CTRL_W   = 16,
    parameter int LBE_BIT  = 7,
    parameter int DTR_BIT  = 8,
    parameter int RTS_BIT  = 9,
    parameter int OUT1_BIT = 10,
    parameter int OUT2_BIT = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_we,
    input  logic [CTRL_W-1:0] ctrl_wdata,
    output logic              loop_en,
    output logic [MS_N-1:0]   ms_flags,
    output logic [MS_N-1:0]   ms_irq
);
    logic [MS_N-1:0] mirror_val;

    // Route each modem output of the written value to its status position.
    always_comb begin
        mirror_val         = '0;
        mirror_val[MS_CTS] = ctrl_wdata[RTS_BIT];
        mirror_val[MS_DSR] = ctrl_wdata[DTR_BIT];
        mirror_val[MS_DCD] = ctrl_wdata[OUT1_BIT];
        mirror_val[MS_RI]  = ctrl_wdata[OUT2_BIT];
    end

    // Track loopback mode and update flags and interrupts on loopback writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            loop_en  <= 1'b0;
            ms_flags <= '0;
            ms_irq   <= '0;
        end else if (ctrl_we) begin
            loop_en <= ctrl_wdata[LBE_BIT];
            if (ctrl_wdata[LBE_BIT]) begin
                ms_flags <= mirror_val;
                ms_irq   <= mirror_val;
            end
        end
    end

    // R2: flags follow the modem outputs of the loopback write.
    p_map_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_we && ctrl_wdata[LBE_BIT] |=>
            ms_flags[MS_CTS] == $past(ctrl_wdata[RTS_BIT]) &&
            ms_flags[MS_DSR] == $past(ctrl_wdata[DTR_BIT]) &&
            ms_flags[MS_DCD] == $past(ctrl_wdata[OUT1_BIT]) &&
            ms_flags[MS_RI]  == $past(ctrl_wdata[OUT2_BIT]) && loop_en);

    // R3: interrupt bits equal the freshly mirrored flag levels.
    p_irq_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_we && ctrl_wdata[LBE_BIT] |=> ms_irq == ms_flags);

    // R4: a non-loopback write leaves flags and interrupts untouched.
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_we && !ctrl_wdata[LBE_BIT] |=>
            $stable(ms_flags) && $stable(ms_irq) && !loop_en);
endmodule

// File: rtl/lbk_break_edge.sv
// Break edge detector: remembers the last written send-break level and
// pulses for one cycle when a write raises it while loopback is on.
// Assumes brk_we marks every write of the send-break control.
module lbk_break_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic brk_we,
    input  logic brk_val,
    input  logic loop_en,
    output logic brk_rise
);
    logic brk_q;

    // Rising edge of the send-break level, qualified by loopback.
    always_comb brk_rise = brk_we && brk_val && !brk_q && loop_en;

    // Store the most recently written send-break level.
    always_ff @(posedge clk) begin
        if (!rst_n)      brk_q <= 1'b0;
        else if (brk_we) brk_q <= brk_val;
    end

    // R6: a repeated 1 never produces an edge.
    p_no_repeat_r6: assert property (@(posedge clk) disable iff (!rst_n)
        brk_we && brk_val |=> !(brk_we && brk_val && brk_rise));
endmodule

// File: rtl/lbk_push_arb.sv
// Push arbiter: chooses the receive entry for this cycle among a loopback
// transmit byte, a loopback break entry and an external byte, and registers
// it as a one-cycle push. A break colliding with a transmit byte waits one
// cycle. Nothing is pushed, and nothing is kept, while the buffer is not ready.
module lbk_push_arb #(
    parameter int DATA_W  = 8,
    parameter int ENTRY_W = DATA_W + 4,
    parameter int BRK_POS = DATA_W + 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               loop_en,
    input  logic               tx_we,
    input  logic [DATA_W-1:0]  tx_wdata,
    input  logic               brk_rise,
    input  logic               ext_valid,
    input  logic [DATA_W-1:0]  ext_data,
    input  logic               rxq_ready,
    output logic               push_valid,
    output logic [ENTRY_W-1:0] push_data
);
    localparam logic [ENTRY_W-1:0] BRK_ENTRY = ENTRY_W'(1) << BRK_POS;

    logic               brk_pend;
    logic               tx_req;
    logic               brk_req;
    logic               ext_req;
    logic [ENTRY_W-1:0] sel_entry;

    // Qualify each source by the loopback mode.
    always_comb begin
        tx_req  = loop_en && tx_we;
        brk_req = loop_en && (brk_rise || brk_pend);
        ext_req = !loop_en && ext_valid;
    end

    // Fixed priority: transmit byte, then break, then external byte.
    always_comb begin
        if (tx_req)       sel_entry = ENTRY_W'(tx_wdata);
        else if (brk_req) sel_entry = BRK_ENTRY;
        else              sel_entry = ENTRY_W'(ext_data);
    end

    // Register the push and defer a break that lost to a transmit byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            push_valid <= 1'b0;
            push_data  <= '0;
            brk_pend   <= 1'b0;
        end else begin
            push_valid <= rxq_ready && (tx_req || brk_req || ext_req);
            push_data  <= sel_entry;
            brk_pend   <= rxq_ready && tx_req && brk_req;
        end
    end

    // R9: a cycle without buffer space yields no push.
    p_not_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !rxq_ready |=> !push_valid);

    // R5: a loopback transmit write is echoed one cycle later.
    p_echo_r5: assert property (@(posedge clk) disable iff (!rst_n)
        loop_en && tx_we && rxq_ready |=>
            push_valid && push_data == ENTRY_W'($past(tx_wdata)));

    // R8: external bytes never reach the buffer in loopback.
    p_ext_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        loop_en && !tx_we && !brk_rise && !brk_pend |=> !push_valid);

    // R7: a break that coincides with a transmit byte follows it.
    p_brk_after_tx_r7: assert property (@(posedge clk) disable iff (!rst_n)
        loop_en && tx_we && brk_rise && rxq_ready |=> brk_pend);
endmodule

// File: rtl/lbk_modem_mirror.sv
// Loopback and modem-status mirror of a serial port: control mirror,
// break edge detector and push arbiter. Assumes single-cycle write strobes
// and a receive buffer that stores push_data whenever push_valid is high.
module lbk_modem_mirror
    import lbk_pkg::*;
#(
    parameter int CTRL_W   = 16,
    parameter int DATA_W   = 8,
    parameter int LBE_BIT  = 7,
    parameter int DTR_BIT  = 8,
    parameter int RTS_BIT  = 9,
    parameter int OUT1_BIT = 10,
    parameter int OUT2_BIT = 11,
    localparam int ENTRY_W = DATA_W + 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ctrl_we,
    input  logic [CTRL_W-1:0]  ctrl_wdata,
    input  logic               tx_we,
    input  logic [DATA_W-1:0]  tx_wdata,
    input  logic               brk_we,
    input  logic               brk_val,
    input  logic               ext_rx_valid,
    input  logic [DATA_W-1:0]  ext_rx_data,
    input  logic               rxq_ready,
    output logic [MS_N-1:0]    ms_flags,
    output logic [MS_N-1:0]    ms_irq,
    output logic               push_valid,
    output logic [ENTRY_W-1:0] push_data,
    output logic               ext_rx_block
);
    logic loop_en;
    logic brk_rise;

    lbk_ctrl_mirror #(
        .CTRL_W(CTRL_W), .LBE_BIT(LBE_BIT), .DTR_BIT(DTR_BIT),
        .RTS_BIT(RTS_BIT), .OUT1_BIT(OUT1_BIT), .OUT2_BIT(OUT2_BIT)
    ) u_mirror (
        .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
        .loop_en(loop_en), .ms_flags(ms_flags), .ms_irq(ms_irq)
    );

    lbk_break_edge u_brk (
        .clk(clk), .rst_n(rst_n), .brk_we(brk_we), .brk_val(brk_val),
        .loop_en(loop_en), .brk_rise(brk_rise)
    );

    lbk_push_arb #(.DATA_W(DATA_W)) u_arb (
        .clk(clk), .rst_n(rst_n), .loop_en(loop_en), .tx_we(tx_we),
        .tx_wdata(tx_wdata), .brk_rise(brk_rise), .ext_valid(ext_rx_valid),
        .ext_data(ext_rx_data), .rxq_ready(rxq_ready),
        .push_valid(push_valid), .push_data(push_data)
    );

    // Gate level toward the receive path follows the loopback mode.
    always_comb ext_rx_block = loop_en;

    // R1: reset clears every output on the next cycle.
    p_reset_r1: assert property (@(posedge clk)
        !rst_n |=> ms_flags == '0 && ms_irq == '0 && !push_valid && !ext_rx_block);

    // R10: with no source active, a push does not repeat.
    p_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        push_valid && !tx_we && !brk_we && !ext_rx_valid &&
        !(push_data[DATA_W+2] == 1'b0 && ext_rx_block) |=> !push_valid);
endmodule

// File: tb/lbk_modem_mirror_tb.sv
// Bench for lbk_modem_mirror: a vector table walked in order, then directed
// reset and not-ready corner tests.
module lbk_modem_mirror_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctrl_we = 1'b0;
    logic [15:0] ctrl_wdata = '0;
    logic        tx_we = 1'b0;
    logic [7:0]  tx_wdata = '0;
    logic        brk_we = 1'b0;
    logic        brk_val = 1'b0;
    logic        ext_rx_valid = 1'b0;
    logic [7:0]  ext_rx_data = '0;
    logic        rxq_ready = 1'b1;
    logic [3:0]  ms_flags;
    logic [3:0]  ms_irq;
    logic        push_valid;
    logic [11:0] push_data;
    logic        ext_rx_block;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    lbk_modem_mirror u_dut (
        .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
        .tx_we(tx_we), .tx_wdata(tx_wdata), .brk_we(brk_we), .brk_val(brk_val),
        .ext_rx_valid(ext_rx_valid), .ext_rx_data(ext_rx_data),
        .rxq_ready(rxq_ready), .ms_flags(ms_flags), .ms_irq(ms_irq),
        .push_valid(push_valid), .push_data(push_data),
        .ext_rx_block(ext_rx_block)
    );

    typedef struct packed {
        logic [7:0]  req;
        logic        cw;
        logic [15:0] cv;
        logic        tw;
        logic [7:0]  tv;
        logic        bw;
        logic        bv;
        logic        ew;
        logic [7:0]  ev;
        logic        rdy;
        logic [3:0]  e_flags;
        logic [3:0]  e_irq;
        logic        e_pv;
        logic [11:0] e_pd;
        logic        e_blk;
    } vec_t;

    localparam int NV = 19;
    // Fields: req, ctrl we/val, tx we/val, brk we/val, ext valid/data, ready,
    // expected flags, irq, push valid, push data, block.
    localparam vec_t VEC [NV] = '{
        '{8'd4,  1'b1,16'h0300, 1'b0,8'h00, 1'b0,1'b0, 1'b0,8'h00, 1'b1, 4'h0,4'h0,1'b0,12'h000,1'b0}, // R4 no loopback
        '{8'd8,  1'b0,16'h0000, 1'b0,8'h00, 1'b0,1'b0, 1'b1,8'h41, 1'b1, 4'h0,4'h0,1'b1,12'h041,1'b0}, // R8 pass
        '{8'd11, 1'b0,16'h0000, 1'b1,8'h55, 1'b0,1'b0, 1'b0,8'h00, 1'b1, 4'h0,4'h0,1'b0,12'h000,1'b0}, // R11
        '{8'd2,  1'b1,16'h0080, 1'b0,8'h00, 1'b0,1'b0, 1'b0,8'h00, 1'b1, 4'h0,4'h0,1'b0,12'h000,1'b1}, // R2 enable only
        '{8'd2,  1'b1,16'h0380, 1'b0,8'h00, 1'b0,1'b0, 1'b0,8'h00, 1'b1, 4'h3,4'h3,1'b0,12'h000,1'b1}, // R2 dtr rts
        '{8'd3,  1'b1,16'h0C80, 1'b0,8'h00, 1'b0,1'b0, 1'b0,8'h00, 1'b1, 4'hC,4'hC,1'b0,12'h000,1'b1}, // R3 drop old bits
        '{8'd5,  1'b0,16'h0000, 1'b1,8'hA5, 1'b0,1'b0, 1'b0,8'h00, 1'b1, 4'hC,4'hC,1'b1,12'h0A5,1'b1}, // R5 echo
        '{8'd8,  1'b0,16'h0000, 1'b0,8'h00, 1'b0,1'b0, 1'b1,8'h33, 1'b1, 4'hC,4'hC,1'b0,12'h000,1'b1}, // R8 discard
        '{8'd6,  1'b0,16'h0000, 1'b0,8'h00, 1'b1,1'b1, 1'b0,8'h00, 1'b1, 4'hC,4'hC,1'b1,12'h400,1'b1}, // R6 rise
        '{8'd6,  1'b0,16'h0000, 1'b0,8'h00, 1'b1,1'b1, 1'b0,8'h00, 1'b1, 4'hC,4'hC,1'b0,12'h000,1'b1}, // R6 1 to 1
        '{8'd6,  1'b0,16'h0000, 1'b0,8'h00, 1'b1,1'b0, 1'b0,8'h00, 1'b1, 4'hC,4'hC,1'b0,12'h000,1'b1}, // R6 fall
        '{8'd9,  1'b0,16'h0000, 1'b1,8'h7E, 1'b0,1'b0, 1'b0,8'h00, 1'b0, 4'hC,4'hC,1'b0,12'h000,1'b1}, // R9 not ready
        '{8'd7,  1'b0,16'h0000, 1'b1,8'h12, 1'b1,1'b1, 1'b0,8'h00, 1'b1, 4'hC,4'hC,1'b1,12'h012,1'b1}, // R7 tx first
        '{8'd7,  1'b0,16'h0000, 1'b0,8'h00, 1'b0,1'b0, 1'b0,8'h00, 1'b1, 4'hC,4'hC,1'b1,12'h400,1'b1}, // R7 break next
        '{8'd10, 1'b0,16'h0000, 1'b0,8'h00, 1'b0,1'b0, 1'b0,8'h00, 1'b1, 4'hC,4'hC,1'b0,12'h000,1'b1}, // R10 pulse ends
        '{8'd4,  1'b1,16'h0F00, 1'b0,8'h00, 1'b0,1'b0, 1'b0,8'h00, 1'b1, 4'hC,4'hC,1'b0,12'h000,1'b0}, // R4 disable keeps
        '{8'd8,  1'b0,16'h0000, 1'b0,8'h00, 1'b0,1'b0, 1'b1,8'hFF, 1'b1, 4'hC,4'hC,1'b1,12'h0FF,1'b0}, // R8 pass 0xFF
        '{8'd6,  1'b0,16'h0000, 1'b0,8'h00, 1'b1,1'b0, 1'b0,8'h00, 1'b1, 4'hC,4'hC,1'b0,12'h000,1'b0}, // R6 clear level
        '{8'd6,  1'b0,16'h0000, 1'b0,8'h00, 1'b1,1'b1, 1'b0,8'h00, 1'b1, 4'hC,4'hC,1'b0,12'h000,1'b0}  // R6 no loopback
    };

    task automatic check(input int req, input logic [3:0] ef, input logic [3:0] ei,
                         input logic epv, input logic [11:0] epd, input logic eblk);
        checks++;
        if (ms_flags !== ef || ms_irq !== ei || push_valid !== epv ||
            (epv && push_data !== epd) || ext_rx_block !== eblk) begin
            errors++;
            $display("FAIL R%0d: flags=%h irq=%h pv=%b pd=%h blk=%b expected flags=%h irq=%h pv=%b pd=%h blk=%b",
                     req, ms_flags, ms_irq, push_valid, push_data, ext_rx_block,
                     ef, ei, epv, epd, eblk);
        end
    endtask

    task automatic drive(input vec_t v);
        ctrl_we = v.cw; ctrl_wdata = v.cv; tx_we = v.tw; tx_wdata = v.tv;
        brk_we = v.bw; brk_val = v.bv; ext_rx_valid = v.ew; ext_rx_data = v.ev;
        rxq_ready = v.rdy;
        @(posedge clk);
        @(negedge clk);
        ctrl_we = 1'b0; tx_we = 1'b0; brk_we = 1'b0; ext_rx_valid = 1'b0;
        rxq_ready = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check(1, 4'h0, 4'h0, 1'b0, 12'h000, 1'b0); // R1 reset state
        for (int i = 0; i < NV; i++) begin
            drive(VEC[i]);
            check(int'(VEC[i].req), VEC[i].e_flags, VEC[i].e_irq,
                  VEC[i].e_pv, VEC[i].e_pd, VEC[i].e_blk);
        end
        // R1: reset mid-run clears mirrored flags and interrupt bits.
        drive('{8'd2, 1'b1,16'h0F80, 1'b0,8'h00, 1'b0,1'b0, 1'b0,8'h00, 1'b1,
                4'hF,4'hF,1'b0,12'h000,1'b1});
        check(2, 4'hF, 4'hF, 1'b0, 12'h000, 1'b1);
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check(1, 4'h0, 4'h0, 1'b0, 12'h000, 1'b0);
        // R9: colliding break and byte with no room: both lost, no retry.
        drive('{8'd9, 1'b1,16'h0080, 1'b0,8'h00, 1'b0,1'b0, 1'b0,8'h00, 1'b1,
                4'h0,4'h0,1'b0,12'h000,1'b1});
        drive('{8'd9, 1'b0,16'h0000, 1'b1,8'h66, 1'b1,1'b1, 1'b0,8'h00, 1'b0,
                4'h0,4'h0,1'b0,12'h000,1'b1});
        check(9, 4'h0, 4'h0, 1'b0, 12'h000, 1'b1);
        @(negedge clk);
        check(9, 4'h0, 4'h0, 1'b0, 12'h000, 1'b1);
        // R5: back-to-back echoes keep order, each one cycle after its write.
        drive('{8'd5, 1'b0,16'h0000, 1'b1,8'h01, 1'b0,1'b0, 1'b0,8'h00, 1'b1,
                4'h0,4'h0,1'b1,12'h001,1'b1});
        check(5, 4'h0, 4'h0, 1'b1, 12'h001, 1'b1);
        drive('{8'd5, 1'b0,16'h0000, 1'b1,8'hFE, 1'b0,1'b0, 1'b0,8'h00, 1'b1,
                4'h0,4'h0,1'b1,12'h0FE,1'b1});
        check(5, 4'h0, 4'h0, 1'b1, 12'h0FE, 1'b1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule